// File: doc/BRIEF.md
# Time-Varying LDPC Convolutional Encoder

This block is a rate-1/2 systematic convolutional encoder. Its parity-check polynomial changes from one time slot to the next and repeats every three slots. It accepts one information bit per cycle through a valid/ready handshake. Each bit carries a start-of-block flag and an end-of-block flag. For every accepted bit the block emits one code pair on the next cycle: the information bit itself, plus a parity bit. The parity bit is the XOR of the current input with selected taps from two long histories, one of past information bits and one of past parity bits.

A block may have any length, from a single bit upward. The start-of-block flag restarts the slot sequence and treats every bit before the block as zero, so each block is encoded from an all-zero state. The output stage is one register deep and applies backpressure. While a pair waits for the consumer, no new bit is taken and neither history moves.

Top module: `tvldpc_encoder`

## Requirements
- R1: For every accepted input bit, exactly one pair is emitted, in acceptance order, and its systematic bit `out_sys` equals the accepted `in_bit`.
- R2: The bit at index t of a block (t = 0 at the bit flagged `in_sob`) is encoded with check equation A when t mod 3 = 0, B when t mod 3 = 1 and C when t mod 3 = 2.
- R3: Under equation A, `out_par` = u(t) ^ u(t-56) ^ u(t-373) ^ p(t-218) ^ p(t-406), where u is the information bit and p is the parity bit at that block index.
- R4: Under equation B, `out_par` = u(t) ^ u(t-197) ^ u(t-457) ^ p(t-22) ^ p(t-491).
- R5: Under equation C, `out_par` = u(t) ^ u(t-70) ^ u(t-485) ^ p(t-181) ^ p(t-236).
- R6: Every information and parity term with a negative block index counts as zero. This holds for the first block after reset and for every later block opened by `in_sob`, whatever the earlier traffic was.
- R7: `out_sob` and `out_eob` repeat the flags of the bit the pair came from. Blocks of any length are encoded, including a one-bit block that carries both flags.
- R8: A bit accepted on a clock edge (`in_valid` and `in_ready` high) appears on the outputs with `out_valid` high right after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, all outputs hold their values on the next edge, and the encoder state does not advance.
- R10: During and right after synchronous reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Encoder can take a bit this cycle |
| in_bit | input | 1 | Information bit |
| in_sob | input | 1 | Bit is the first of a block |
| in_eob | input | 1 | Bit is the last of a block |
| out_valid | output | 1 | Code pair present |
| out_ready | input | 1 | Consumer takes the pair this cycle |
| out_sys | output | 1 | Systematic bit |
| out_par | output | 1 | Parity bit |
| out_sob | output | 1 | Pair belongs to the first bit of a block |
| out_eob | output | 1 | Pair belongs to the last bit of a block |

## Verification
Two things can happen in the same cycle: the consumer drains the registered pair, and a new bit is accepted and shifted into both histories. The bench drives random consumer readiness and random input gaps, so drains, refills and stalls all occur back to back, sometimes in the same cycle. A bench model indexed by block position checks every drained pair, in order, against the tap equations. A lost, doubled or early-shifted bit therefore shows up as a parity mismatch, sometimes hundreds of bits later. Directed blocks add an impulse long enough to reach the deepest taps, an all-ones block, a one-bit block, and a new block opened right after a block whose length is not a multiple of three.

// File: rtl/tvldpc_pkg.sv
package tvldpc_pkg;

  // number of check equations in one period
  localparam int unsigned TV_SLOTS = 3;

  // nonzero information delays of each equation (the zero delay is implicit)
  localparam int unsigned TV_INFO_TAPS [TV_SLOTS][2] = '{
    '{56, 373},
    '{197, 457},
    '{70, 485}
  };

  // nonzero parity delays of each equation (the zero delay is implicit)
  localparam int unsigned TV_PAR_TAPS [TV_SLOTS][2] = '{
    '{218, 406},
    '{22, 491},
    '{181, 236}
  };

  typedef struct packed {
    logic sys;
    logic par;
    logic sob;
    logic eob;
  } code_pair_t;

endpackage

// File: rtl/tvldpc_slot_ctr.sv
module tvldpc_slot_ctr #(
  parameter int unsigned NUM_SLOTS = 3,
  localparam int unsigned SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          restart,
  output logic [SW-1:0] slot
);

  logic [SW-1:0] slot_q;

  // a restart applies to the bit that carries it
  assign slot = restart ? '0 : slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (adv) begin
      slot_q <= (slot == SW'(NUM_SLOTS - 1)) ? '0 : slot + SW'(1);
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_q < SW'(NUM_SLOTS)); // R2

  AST_SOB_SLOT: assert property (@(posedge clk) disable iff (rst)
    (adv && restart) |=> (slot_q == SW'((NUM_SLOTS > 1) ? 1 : 0))); // R2

endmodule

// File: rtl/tvldpc_hist.sv
module tvldpc_hist #(
  parameter int unsigned NUM_SLOTS = 3,
  parameter int unsigned TAPS [NUM_SLOTS][2] = '{'{1, 2}, '{1, 2}, '{1, 2}},
  localparam int unsigned NT = NUM_SLOTS * 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift,
  input  logic          clear,
  input  logic          din,
  output logic [NT-1:0] tap_bits
);

  function automatic int unsigned deepest();
    int unsigned m = 2;
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      for (int k = 0; k < 2; k++) begin
        if (TAPS[s][k] > m) m = TAPS[s][k];
      end
    end
    return m;
  endfunction

  localparam int unsigned DEPTH = deepest();

  // hist_q[k-1] holds the bit from k accepted steps ago
  logic [DEPTH-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift) begin
      if (clear) begin
        hist_q <= {{(DEPTH-1){1'b0}}, din};
      end else begin
        hist_q <= {hist_q[DEPTH-2:0], din};
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar k = 0; k < 2; k++) begin : g_tap
      assign tap_bits[s*2+k] = clear ? 1'b0 : hist_q[TAPS[s][k]-1];
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (shift && clear) |=> (hist_q[DEPTH-1:1] == '0)); // R6

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(hist_q)); // R9

endmodule

// File: rtl/tvldpc_parity.sv
module tvldpc_parity #(
  parameter int unsigned NUM_SLOTS = 3,
  localparam int unsigned SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned NT = NUM_SLOTS * 2
) (
  input  logic [SW-1:0] slot,
  input  logic          u_now,
  input  logic [NT-1:0] info_taps,
  input  logic [NT-1:0] par_taps,
  output logic          parity
);

  logic [NUM_SLOTS-1:0] partial;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_eq
    assign partial[s] = info_taps[s*2] ^ info_taps[s*2+1]
                      ^ par_taps[s*2] ^ par_taps[s*2+1];
  end

  always_comb begin
    parity = u_now;
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      if (slot == SW'(s)) parity = u_now ^ partial[s];
    end
  end

endmodule

// File: rtl/tvldpc_encoder.sv
module tvldpc_encoder
  import tvldpc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = TV_SLOTS,
  parameter int unsigned INFO_TAPS [NUM_SLOTS][2] = TV_INFO_TAPS,
  parameter int unsigned PAR_TAPS  [NUM_SLOTS][2] = TV_PAR_TAPS
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_sob,
  input  logic in_eob,
  output logic out_valid,
  input  logic out_ready,
  output logic out_sys,
  output logic out_par,
  output logic out_sob,
  output logic out_eob
);

  localparam int unsigned SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int unsigned NT = NUM_SLOTS * 2;

  logic          accept;
  logic [SW-1:0] slot;
  logic [NT-1:0] info_taps;
  logic [NT-1:0] par_taps;
  logic          parity;
  logic          valid_q;
  code_pair_t    pair_q;

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  tvldpc_slot_ctr #(.NUM_SLOTS(NUM_SLOTS)) u_slot (
    .clk(clk), .rst(rst), .adv(accept), .restart(in_sob), .slot(slot)
  );

  tvldpc_hist #(.NUM_SLOTS(NUM_SLOTS), .TAPS(INFO_TAPS)) u_info_hist (
    .clk(clk), .rst(rst), .shift(accept), .clear(in_sob),
    .din(in_bit), .tap_bits(info_taps)
  );

  tvldpc_hist #(.NUM_SLOTS(NUM_SLOTS), .TAPS(PAR_TAPS)) u_par_hist (
    .clk(clk), .rst(rst), .shift(accept), .clear(in_sob),
    .din(parity), .tap_bits(par_taps)
  );

  tvldpc_parity #(.NUM_SLOTS(NUM_SLOTS)) u_parity (
    .slot(slot), .u_now(in_bit), .info_taps(info_taps),
    .par_taps(par_taps), .parity(parity)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      pair_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      pair_q  <= '{sys: in_bit, par: parity, sob: in_sob, eob: in_eob};
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_sys   = pair_q.sys;
  assign out_par   = pair_q.par;
  assign out_sob   = pair_q.sob;
  assign out_eob   = pair_q.eob;

  AST_SYS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_valid && out_sys == $past(in_bit))); // R1

  AST_MARK_FWD: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_sob == $past(in_sob) && out_eob == $past(in_eob))); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(pair_q))); // R9

endmodule

// File: tb/tb_tvldpc_encoder.sv
module tb_tvldpc_encoder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, in_sob = 1'b0, in_eob = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_sys, out_par, out_sob, out_eob;

  always #10 clk = ~clk; // 50 MHz

  tvldpc_encoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_sob(in_sob), .in_eob(in_eob),
    .out_valid(out_valid), .out_ready(out_ready), .out_sys(out_sys),
    .out_par(out_par), .out_sob(out_sob), .out_eob(out_eob)
  );

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the code, indexed by position in block
  bit mu [0:4095];
  bit mp [0:4095];
  int cur_t = 0;
  logic [4:0] exp_q [$]; // {sys, par, sob, eob, slot_is_any} packed below
  int slot_q [$];

  int ready_pct = 100;
  int gap_pct = 0;
  bit acc_last = 0;
  bit hold_pend = 0;
  logic [3:0] held;

  function automatic bit gu(int t);
    return (t < 0) ? 1'b0 : mu[t];
  endfunction
  function automatic bit gp(int t);
    return (t < 0) ? 1'b0 : mp[t];
  endfunction

  function automatic bit model_par(int t, bit u);
    case (t % 3)
      0: return u ^ gu(t-56) ^ gu(t-373) ^ gp(t-218) ^ gp(t-406);   // R3
      1: return u ^ gu(t-197) ^ gu(t-457) ^ gp(t-22) ^ gp(t-491);   // R4
      default: return u ^ gu(t-70) ^ gu(t-485) ^ gp(t-181) ^ gp(t-236); // R5
    endcase
  endfunction

  task automatic fail(string req, string what, int got, int exp);
    n_fail++;
    $display("FAIL %s: %s got %0d exp %0d", req, what, got, exp);
  endtask

  task automatic step();
    logic [4:0] e;
    int sl;
    string rq;
    #1;
    if (acc_last) begin
      n_chk++;
      if (!out_valid) fail("R8", "out_valid after accept", out_valid, 1);
    end
    if (hold_pend) begin
      n_chk++;
      if (!out_valid || {out_sys, out_par, out_sob, out_eob} != held)
        fail("R9", "held pair", {out_valid, out_sys, out_par, out_sob, out_eob}, {1'b1, held});
    end
    hold_pend = out_valid && !out_ready;
    if (hold_pend) begin
      held = {out_sys, out_par, out_sob, out_eob};
      n_chk++;
      if (in_ready) fail("R9", "in_ready while stalled", in_ready, 0);
    end
    if (out_valid && out_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        fail("R1", "unexpected pair count", 1, 0);
      end else begin
        e = exp_q.pop_front();
        sl = slot_q.pop_front();
        rq = (sl == 0) ? "R2 R3 R6" : (sl == 1) ? "R2 R4 R6" : "R2 R5 R6";
        if (out_sys != e[4]) fail("R1", "systematic bit", out_sys, e[4]);
        else if (out_par != e[3]) fail(rq, "parity bit", out_par, e[3]);
        else if ({out_sob, out_eob} != e[2:1]) fail("R7", "markers", {out_sob, out_eob}, e[2:1]);
      end
    end
    acc_last = in_valid && in_ready;
    if (acc_last) begin
      int t;
      bit p;
      t = in_sob ? 0 : cur_t;
      p = model_par(t, in_bit);
      mu[t] = in_bit;
      mp[t] = p;
      cur_t = t + 1;
      exp_q.push_back({in_bit, p, in_sob, in_eob, 1'b0});
      slot_q.push_back(t % 3);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rnd_ready();
    out_ready = (($urandom % 100) < ready_pct);
  endtask

  task automatic send_bit(bit b, bit s, bit e);
    while (($urandom % 100) < gap_pct) begin
      in_valid = 1'b0;
      rnd_ready();
      step();
    end
    in_valid = 1'b1; in_bit = b; in_sob = s; in_eob = e;
    rnd_ready();
    step();
    while (!acc_last) begin
      rnd_ready();
      step();
    end
    in_valid = 1'b0; in_sob = 1'b0; in_eob = 1'b0;
  endtask

  // kind 0: random, 1: impulse, 2: all ones
  task automatic send_block(int len, int kind);
    for (int i = 0; i < len; i++) begin
      bit b;
      b = (kind == 0) ? bit'($urandom % 2) : (kind == 1) ? (i == 0) : 1'b1;
      send_bit(b, i == 0, i == len - 1);
    end
  endtask

  task automatic drain();
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) step();
    n_chk++;
    if (exp_q.size() != 0) fail("R1", "pairs left undelivered", exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0c0d));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    n_chk++;
    if (out_valid !== 1'b0) fail("R10", "out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    n_chk++;
    if (out_valid !== 1'b0) fail("R10", "out_valid after reset", out_valid, 0);
    n_chk++;
    if (in_ready !== 1'b1) fail("R10", "in_ready after reset", in_ready, 1);
    @(negedge clk);

    // R7: single-bit block with both markers
    send_block(1, 0);
    // R3 R4 R5 R6: impulse reaching past the deepest taps, full throughput
    send_block(1100, 1);
    // all ones, then a block of length not a multiple of three (R2)
    send_block(300, 2);
    send_block(7, 0);
    send_block(20, 0);
    drain();

    // R9 R8: random backpressure and gaps; drain and refill in the same cycle
    ready_pct = 60;
    gap_pct = 25;
    for (int b = 0; b < 8; b++) begin
      send_block(1 + int'($urandom % 700), 0);
    end
    ready_pct = 30;
    gap_pct = 0;
    send_block(600, 0);
    send_block(1, 1);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish got %0d exp %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule